// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for one load or store per cycle and decides how the base register changes. It takes a base value and an offset, which is either a small zero-extended immediate or a register value shifted left by up to 31 places. It adds the offset to the base or subtracts it. Three addressing modes are supported. In plain offset mode the access uses the combined value and the base is left alone. In pre-index mode the access uses the combined value and the base is also updated to it. In post-index mode the access uses the untouched base and the base is updated to the combined value afterwards.

A per-access kind input lets the unit reject combinations it does not support. A rejected request raises an illegal flag and never requests a base update. All outputs are registered, so each result appears one clock after its valid strobe. The data memory, the register file and the data path are outside this block.

Top module: `ls_agu`

## Requirements
- R1: With `amode` = 2'b00 (plain offset), `eff_addr` is the base combined with the offset, `wb_en` is 0 and `wb_val` equals the base.
- R2: With `amode` = 2'b01 (pre-index with update), `eff_addr` is the base combined with the offset, `wb_en` is 1 and `wb_val` equals `eff_addr`.
- R3: With `amode` = 2'b10 (post-index), `eff_addr` equals the unmodified base, `wb_en` is 1 and `wb_val` is the base combined with the offset.
- R4: With `off_src` = 0 the offset is `imm_off`, zero-extended from 12 bits to 32 bits; `reg_off` and `shamt` have no effect on the result.
- R5: With `off_src` = 1 the offset is `reg_off` shifted left logically by `shamt` (0 to 31), and bits shifted past bit 31 are dropped.
- R6: `add_dir` = 1 adds the offset to the base and `add_dir` = 0 subtracts it, both modulo 2^32.
- R7: `amode` = 2'b11 is reserved: it sets `illegal` to 1, `wb_en` to 0, and both `eff_addr` and `wb_val` to the base.
- R8: A register offset (`off_src` = 1) with a nonzero `shamt` on a halfword access (`acc_kind` = 2'b10 halfword or 2'b11 signed halfword) sets `illegal`, clears `wb_en` and gives the base on `eff_addr` and `wb_val`. Word (2'b00) and byte (2'b01) kinds, immediate offsets and a zero shift are legal.
- R9: The results of a request with `in_valid` = 1 appear on the outputs at the next rising clock edge, together with `res_valid` = 1.
- R10: A cycle with `in_valid` = 0 gives `res_valid`, `wb_en` and `illegal` = 0 at the next edge, and `eff_addr` and `wb_val` keep their values.
- R11: A synchronous active-high `rst` clears `res_valid`, `wb_en`, `illegal`, `eff_addr` and `wb_val` to 0 at the next edge, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset, zero-extended |
| reg_off | input | 32 | Register offset value |
| shamt | input | 5 | Left shift applied to the register offset |
| amode | input | 2 | 00 offset, 01 pre-index with update, 10 post-index, 11 reserved |
| off_src | input | 1 | 0 immediate offset, 1 shifted register offset |
| add_dir | input | 1 | 1 add the offset, 0 subtract it |
| acc_kind | input | 2 | 00 word, 01 byte, 10 halfword, 11 signed halfword |
| res_valid | output | 1 | Registered result valid |
| eff_addr | output | 32 | Registered access address |
| wb_en | output | 1 | Registered base update enable |
| wb_val | output | 32 | Registered new base value |
| illegal | output | 1 | Registered unsupported-combination flag |

## Verification
The assertions watch every cycle for the rules that tie the outputs to each other and to the mode: no update request together with the illegal flag, no update in plain offset mode, a pre-index update equal to the access address, a post-index address equal to the previous base, the reserved mode and the shifted halfword case always flagged, and the outputs held and quiet when no request came. The exact arithmetic, meaning the zero extension of the immediate, the dropping of high bits in a large shift, subtraction that wraps past zero and the sum that wraps past 2^32, can only be shown by the bench. It compares each result against its own model over random and directed requests. The bench alone also shows that reset clears the outputs while a request is present.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'b00,
    AM_PRE_WB = 2'b01,
    AM_POST   = 2'b10,
    AM_RSVD   = 2'b11
  } agu_mode_e;

  typedef enum logic [1:0] {
    AK_WORD  = 2'b00,
    AK_BYTE  = 2'b01,
    AK_HALF  = 2'b10,
    AK_SHALF = 2'b11
  } agu_kind_e;

  typedef enum logic {
    OS_IMM = 1'b0,
    OS_REG = 1'b1
  } agu_osrc_e;

endpackage

// File: rtl/agu_offset_gen.sv
module agu_offset_gen #(
  parameter int DW   = 32,
  parameter int IMMW = 12,
  parameter int SHW  = 5
) (
  input  logic [IMMW-1:0] imm_i,
  input  logic [DW-1:0]   reg_i,
  input  logic [SHW-1:0]  shamt_i,
  input  logic            src_i,
  output logic [DW-1:0]   off_o
);
  import ls_agu_pkg::*;

  localparam int PAD_W = DW - IMMW;

  function automatic logic [DW-1:0] zext_imm(input logic [IMMW-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  function automatic logic [DW-1:0] shl_reg(input logic [DW-1:0] v,
                                            input logic [SHW-1:0] s);
    return v << s;
  endfunction

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] reg_shifted;

  assign imm_ext     = zext_imm(imm_i);
  assign reg_shifted = shl_reg(reg_i, shamt_i);

  always_comb begin
    if (agu_osrc_e'(src_i) == OS_REG) off_o = reg_shifted;
    else                              off_o = imm_ext;
  end

endmodule

// File: rtl/agu_legal_chk.sv
module agu_legal_chk #(
  parameter int SHW = 5
) (
  input  logic [1:0]     mode_i,
  input  logic           src_i,
  input  logic [1:0]     kind_i,
  input  logic [SHW-1:0] shamt_i,
  output logic           rsvd_o,
  output logic           half_shift_o,
  output logic           illegal_o
);
  import ls_agu_pkg::*;

  logic is_half;
  logic reg_shifted;

  always_comb begin
    is_half      = (agu_kind_e'(kind_i) == AK_HALF) || (agu_kind_e'(kind_i) == AK_SHALF);
    reg_shifted  = (agu_osrc_e'(src_i) == OS_REG) && (shamt_i != '0);
    rsvd_o       = (agu_mode_e'(mode_i) == AM_RSVD);
    half_shift_o = is_half && reg_shifted;
    illegal_o    = rsvd_o || half_shift_o;
  end

endmodule

// File: rtl/agu_mode_sel.sv
module agu_mode_sel #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  input  logic          up_i,
  input  logic [1:0]    mode_i,
  input  logic          illegal_i,
  output logic [DW-1:0] step_o,
  output logic [DW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_val_o
);
  import ls_agu_pkg::*;

  function automatic logic [DW-1:0] step_base(input logic [DW-1:0] b,
                                              input logic [DW-1:0] o,
                                              input logic          up);
    return up ? (b + o) : (b - o);
  endfunction

  assign step_o = step_base(base_i, off_i, up_i);

  always_comb begin
    addr_o   = base_i;
    wb_en_o  = 1'b0;
    wb_val_o = base_i;
    if (!illegal_i) begin
      unique case (agu_mode_e'(mode_i))
        AM_OFFSET: begin
          addr_o = step_o;
        end
        AM_PRE_WB: begin
          addr_o   = step_o;
          wb_en_o  = 1'b1;
          wb_val_o = step_o;
        end
        AM_POST: begin
          wb_en_o  = 1'b1;
          wb_val_o = step_o;
        end
        default: begin
          addr_o = base_i;
        end
      endcase
    end
  end

endmodule

// File: rtl/ls_agu.sv
module ls_agu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] base_val,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [DATA_W-1:0] reg_off,
  input  logic [SH_W-1:0]   shamt,
  input  logic [1:0]        amode,
  input  logic              off_src,
  input  logic              add_dir,
  input  logic [1:0]        acc_kind,
  output logic              res_valid,
  output logic [DATA_W-1:0] eff_addr,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_val,
  output logic              illegal
);
  import ls_agu_pkg::*;

  logic [DATA_W-1:0] off_c;
  logic [DATA_W-1:0] step_c;
  logic [DATA_W-1:0] addr_c;
  logic [DATA_W-1:0] wbv_c;
  logic              wbe_c;
  logic              rsvd_c;
  logic              half_shift_c;
  logic              ill_c;

  agu_offset_gen #(.DW(DATA_W), .IMMW(IMM_W), .SHW(SH_W)) u_off (
    .imm_i   (imm_off),
    .reg_i   (reg_off),
    .shamt_i (shamt),
    .src_i   (off_src),
    .off_o   (off_c)
  );

  agu_legal_chk #(.SHW(SH_W)) u_legal (
    .mode_i       (amode),
    .src_i        (off_src),
    .kind_i       (acc_kind),
    .shamt_i      (shamt),
    .rsvd_o       (rsvd_c),
    .half_shift_o (half_shift_c),
    .illegal_o    (ill_c)
  );

  agu_mode_sel #(.DW(DATA_W)) u_mode (
    .base_i    (base_val),
    .off_i     (off_c),
    .up_i      (add_dir),
    .mode_i    (amode),
    .illegal_i (ill_c),
    .step_o    (step_c),
    .addr_o    (addr_c),
    .wb_en_o   (wbe_c),
    .wb_val_o  (wbv_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      eff_addr  <= '0;
      wb_en     <= 1'b0;
      wb_val    <= '0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        eff_addr <= addr_c;
        wb_en    <= wbe_c;
        wb_val   <= wbv_c;
        illegal  <= ill_c;
      end else begin
        wb_en    <= 1'b0;
        illegal  <= 1'b0;
      end
    end
  end

  AST_WB_NOT_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wb_en); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!wb_en && !illegal)); // R10

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid); // R9

  AST_NO_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid); // R10

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(eff_addr) && $stable(wb_val))); // R10

  AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (in_valid && agu_mode_e'(amode) == AM_OFFSET) |=> !wb_en); // R1

  AST_PRE_SAME: assert property (@(posedge clk) disable iff (rst)
    (in_valid && agu_mode_e'(amode) == AM_PRE_WB && !ill_c) |=> (wb_en && wb_val == eff_addr)); // R2

  AST_POST_BASE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && agu_mode_e'(amode) == AM_POST && !ill_c) |=> (wb_en && eff_addr == $past(base_val))); // R3

  AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rsvd_c) |=> (illegal && !wb_en)); // R7

  AST_HALF_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_shift_c) |=> (illegal && eff_addr == $past(base_val))); // R8

endmodule

// File: tb/ls_agu_tb.sv
module ls_agu_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] base_val;
  logic [11:0] imm_off;
  logic [31:0] reg_off;
  logic [4:0]  shamt;
  logic [1:0]  amode;
  logic        off_src;
  logic        add_dir;
  logic [1:0]  acc_kind;
  logic        res_valid;
  logic [31:0] eff_addr;
  logic        wb_en;
  logic [31:0] wb_val;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ls_agu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .base_val(base_val),
    .imm_off(imm_off), .reg_off(reg_off), .shamt(shamt), .amode(amode),
    .off_src(off_src), .add_dir(add_dir), .acc_kind(acc_kind),
    .res_valid(res_valid), .eff_addr(eff_addr), .wb_en(wb_en),
    .wb_val(wb_val), .illegal(illegal)
  );

  function automatic logic [31:0] mdl_offset(input logic [11:0] imm, input logic [31:0] ro,
                                             input logic [4:0] sh, input logic src);
    logic [63:0] prod;
    prod = {32'd0, ro} * (64'd1 << sh);
    if (src) return prod[31:0];
    return 32'h0000_0FFF & {20'd0, imm};
  endfunction

  function automatic logic [31:0] mdl_step(input logic [31:0] b, input logic [31:0] o, input logic up);
    logic [32:0] t;
    if (up) t = {1'b0, b} + {1'b0, o};
    else    t = {1'b0, b} + {1'b0, ~o} + 33'd1;
    return t[31:0];
  endfunction

  function automatic bit mdl_illegal(input logic [1:0] m, input logic src,
                                     input logic [4:0] sh, input logic [1:0] k);
    if (m == 2'b11) return 1'b1;
    if (src && sh != 5'd0 && k[1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] last_addr;
  logic [31:0] last_wbv;

  task automatic run_vec(input string tag, input logic [31:0] b, input logic [11:0] imm,
                         input logic [31:0] ro, input logic [4:0] sh, input logic [1:0] m,
                         input logic src, input logic up, input logic [1:0] k);
    logic [31:0] st, ea, wv;
    logic        we, il;
    in_valid = 1'b1; base_val = b; imm_off = imm; reg_off = ro; shamt = sh;
    amode = m; off_src = src; add_dir = up; acc_kind = k;
    st = mdl_step(b, mdl_offset(imm, ro, sh, src), up);
    il = mdl_illegal(m, src, sh, k);
    ea = b; we = 1'b0; wv = b;
    if (!il) begin
      case (m)
        2'b00: ea = st;
        2'b01: begin ea = st; we = 1'b1; wv = st; end
        default: begin we = 1'b1; wv = st; end
      endcase
    end
    @(negedge clk);
    chk("R9", "res_valid", {31'd0, res_valid}, 32'd1);
    chk(tag, "eff_addr", eff_addr, ea);
    chk(tag, "wb_en", {31'd0, wb_en}, {31'd0, we});
    chk(tag, "wb_val", wb_val, wv);
    chk(tag, "illegal", {31'd0, illegal}, {31'd0, il});
    last_addr = ea;
    last_wbv  = wv;
  endtask

  task automatic run_idle();
    in_valid = 1'b0;
    base_val = $urandom; reg_off = $urandom; imm_off = 12'($urandom);
    shamt = 5'($urandom); amode = 2'($urandom); off_src = 1'($urandom);
    add_dir = 1'($urandom); acc_kind = 2'($urandom);
    @(negedge clk);
    chk("R10", "res_valid", {31'd0, res_valid}, 32'd0);
    chk("R10", "wb_en", {31'd0, wb_en}, 32'd0);
    chk("R10", "illegal", {31'd0, illegal}, 32'd0);
    chk("R10", "eff_addr", eff_addr, last_addr);
    chk("R10", "wb_val", wb_val, last_wbv);
  endtask

  task automatic chk_reset(input string tag);
    chk(tag, "res_valid", {31'd0, res_valid}, 32'd0);
    chk(tag, "wb_en", {31'd0, wb_en}, 32'd0);
    chk(tag, "illegal", {31'd0, illegal}, 32'd0);
    chk(tag, "eff_addr", eff_addr, 32'd0);
    chk(tag, "wb_val", wb_val, 32'd0);
  endtask

  function automatic string mode_tag(input logic [1:0] m, input logic src,
                                     input logic [4:0] sh, input logic [1:0] k);
    if (m == 2'b11) return "R7";
    if (mdl_illegal(m, src, sh, k)) return "R8";
    if (m == 2'b00) return "R1";
    if (m == 2'b01) return "R2";
    return "R3";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A61));
    rst = 1'b1; in_valid = 1'b1; base_val = 32'h1234_5678; imm_off = 12'h010;
    reg_off = 32'd0; shamt = 5'd0; amode = 2'b01; off_src = 1'b0; add_dir = 1'b1;
    acc_kind = 2'b00;
    repeat (3) @(negedge clk);
    chk_reset("R11");
    rst = 1'b0;

    // directed corners
    run_vec("R1", 32'h0000_1000, 12'h004, 32'h0, 5'd0, 2'b00, 1'b0, 1'b1, 2'b00);
    run_vec("R2", 32'h0000_1000, 12'h004, 32'h0, 5'd0, 2'b01, 1'b0, 1'b1, 2'b00);
    run_vec("R3", 32'h0000_1000, 12'h004, 32'h0, 5'd0, 2'b10, 1'b0, 1'b1, 2'b00);
    run_vec("R4", 32'h8000_0000, 12'hFFF, 32'hDEAD_BEEF, 5'd7, 2'b00, 1'b0, 1'b1, 2'b10);
    run_vec("R5", 32'h0000_0100, 12'h0, 32'h0000_0003, 5'd2, 2'b00, 1'b1, 1'b1, 2'b00);
    run_vec("R5", 32'h0000_0000, 12'h0, 32'hFFFF_FFFF, 5'd31, 2'b01, 1'b1, 1'b1, 2'b01);
    run_vec("R6", 32'h0000_0002, 12'h005, 32'h0, 5'd0, 2'b01, 1'b0, 1'b0, 2'b00);
    run_vec("R6", 32'hFFFF_FFFE, 12'h005, 32'h0, 5'd0, 2'b10, 1'b0, 1'b1, 2'b00);
    run_vec("R7", 32'hCAFE_0000, 12'h123, 32'h0, 5'd0, 2'b11, 1'b0, 1'b1, 2'b00);
    run_vec("R8", 32'h0000_4000, 12'h0, 32'h0000_0010, 5'd1, 2'b01, 1'b1, 1'b1, 2'b10);
    run_vec("R8", 32'h0000_4000, 12'h0, 32'h0000_0010, 5'd3, 2'b10, 1'b1, 1'b0, 2'b11);
    run_vec("R8", 32'h0000_4000, 12'h0, 32'h0000_0010, 5'd0, 2'b10, 1'b1, 1'b1, 2'b10);
    run_vec("R8", 32'h0000_4000, 12'h0, 32'h0000_0010, 5'd4, 2'b01, 1'b1, 1'b1, 2'b01);
    run_idle();
    run_idle();

    // reset while a request is present
    run_vec("R2", 32'h0000_5000, 12'h008, 32'h0, 5'd0, 2'b01, 1'b0, 1'b1, 2'b00);
    rst = 1'b1;
    @(negedge clk);
    chk_reset("R11");
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m, k;
      logic [4:0] sh;
      logic       src;
      m   = 2'($urandom);
      k   = 2'($urandom);
      src = 1'($urandom);
      sh  = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      if ($urandom_range(0, 9) == 0) run_idle();
      else run_vec(mode_tag(m, src, sh, k), $urandom, 12'($urandom), $urandom, sh,
                   m, src, 1'($urandom), k);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule